// File: doc/BRIEF.md
# Two-Stage Channel Priority Arbiter

This block chooses which of several transfer channels is served next when more than one of them is waiting. Each channel carries a 2-bit software level programmed by its owner. The arbiter first keeps only the waiting channels at the highest level present. Among those survivors it then applies a fixed order in which the lowest channel number wins.

A decision is taken only while no grant is held and the shared bus reports idle. The winner is registered, and its grant stays frozen until the access completion strobe arrives. Every interface here is a plain control signal, with no valid/ready stream. The pending vector is sampled level-wise, and completion works as the only form of back-pressure: the grant does not move until `access_done` is seen.

Top module: `arb2_channel_arbiter`

## Requirements
- R1: After reset (active-low `rst_n`) `grant` is all zeros, `grant_idx` is 0 and `grant_valid` is low.
- R2: With no bit of `req_pending` set and no grant held, `grant` stays all zeros and `grant_valid` stays low.
- R3: The software level of channel i is `chan_prio[2i+1:2i]`, encoded 00 low, 01 medium, 10 high, 11 ultra high. A new grant goes to a pending channel whose level is the highest among all pending channels.
- R4: When several pending channels share that highest level, the one with the lowest index is granted.
- R5: A new grant is taken only at a clock edge where no grant is held and `bus_idle` is high. It becomes visible on the outputs after that edge. With `bus_idle` low, no grant is made.
- R6: While a grant is held and `access_done` is low, `grant` and `grant_idx` stay unchanged whatever `req_pending`, `chan_prio` or `bus_idle` do.
- R7: At an edge where a grant is held and `access_done` is high, the grant is released: `grant` becomes zero and `grant_valid` goes low after that edge. `access_done` has no effect while no grant is held.
- R8: `grant` is one-hot or zero, `grant_valid` equals the OR of `grant`, and `grant_idx` is the position of the set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pending | input | NUM_CH | One bit per channel waiting for service |
| chan_prio | input | 2*NUM_CH | Per-channel software level, 2 bits each |
| bus_idle | input | 1 | Shared bus free, a new grant may be made |
| access_done | input | 1 | The granted channel's access has completed |
| grant | output | NUM_CH | One-hot grant |
| grant_idx | output | IDX_W | Index of the granted channel |
| grant_valid | output | 1 | A grant is held |

## Verification
The hardest case to reach is a held grant that must stay frozen while the inputs around it change. Here, higher-level requests arrive and levels are reprogrammed during the hold. Right after release, the next winner must come from the inputs present at that later edge. A random stream reaches this case by drawing completion only about a third of the time and redrawing pending bits and levels every cycle. Directed steps also force ties at each level and an ultra-high request on the top channel arriving mid-hold.

// File: rtl/arb2_pkg.sv
package arb2_pkg;
  typedef enum logic [1:0] {
    LVL_LOW    = 2'b00,
    LVL_MEDIUM = 2'b01,
    LVL_HIGH   = 2'b10,
    LVL_ULTRA  = 2'b11
  } level_e;
  localparam int LVL_W = 2;
endpackage

// File: rtl/arb2_level_mask.sv
module arb2_level_mask
  import arb2_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         pend,
  input  logic [NUM_CH*LVL_W-1:0]   prio,
  output logic [NUM_CH-1:0]         top_mask
);
  level_e max_lvl;

  // Stage one: highest software level among pending channels
  always_comb begin
    max_lvl = LVL_LOW;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pend[i] && (level_e'(prio[i*LVL_W +: LVL_W]) > max_lvl))
        max_lvl = level_e'(prio[i*LVL_W +: LVL_W]);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
    assign top_mask[g] = pend[g] && (level_e'(prio[g*LVL_W +: LVL_W]) == max_lvl);
  end

  // A pending request always leaves at least one survivor (R3)
  assert_survivor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |-> (|top_mask));
endmodule

// File: rtl/arb2_first_pick.sv
module arb2_first_pick #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] cand,
  output logic [NUM_CH-1:0] onehot,
  output logic [IDX_W-1:0]  idx
);
  // Stage two: lowest index wins
  assign onehot = cand & (~cand + NUM_CH'(1));

  always_comb begin
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/arb2_channel_arbiter.sv
module arb2_channel_arbiter
  import arb2_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       req_pending,
  input  logic [NUM_CH*LVL_W-1:0] chan_prio,
  input  logic                    bus_idle,
  input  logic                    access_done,
  output logic [NUM_CH-1:0]       grant,
  output logic [IDX_W-1:0]        grant_idx,
  output logic                    grant_valid
);
  logic [NUM_CH-1:0] top_mask;
  logic [NUM_CH-1:0] pick_oh;
  logic [IDX_W-1:0]  pick_idx;
  logic [NUM_CH-1:0] grant_q;
  logic [IDX_W-1:0]  idx_q;
  logic              held_q;
  logic              take;

  arb2_level_mask #(.NUM_CH(NUM_CH)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (req_pending),
    .prio     (chan_prio),
    .top_mask (top_mask)
  );

  arb2_first_pick #(.NUM_CH(NUM_CH)) u_pick (
    .cand   (top_mask),
    .onehot (pick_oh),
    .idx    (pick_idx)
  );

  assign take = !held_q && bus_idle && (|req_pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      idx_q   <= '0;
      held_q  <= 1'b0;
    end else if (held_q) begin
      if (access_done) begin
        grant_q <= '0;
        idx_q   <= '0;
        held_q  <= 1'b0;
      end
    end else if (take) begin
      grant_q <= pick_oh;
      idx_q   <= pick_idx;
      held_q  <= 1'b1;
    end
  end

  assign grant       = grant_q;
  assign grant_idx   = idx_q;
  assign grant_valid = held_q;

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q) && (held_q == (|grant_q)));
  assert_idx_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> grant_q[idx_q]);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !access_done) |=> ($stable(grant_q) && $stable(idx_q)));
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && access_done) |=> !held_q);
  assert_busy_no_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_q && !bus_idle) |=> !held_q);
  assert_empty_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_q && !(|req_pending)) |=> !held_q);
endmodule

// File: tb/arb2_channel_arbiter_test.sv
`timescale 1ns/1ps
module arb2_channel_arbiter_test;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_pending = '0;
  logic [2*N-1:0] chan_prio = '0;
  logic          bus_idle = 1'b0;
  logic          access_done = 1'b0;
  logic [N-1:0]  grant;
  logic [IW-1:0] grant_idx;
  logic          grant_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit m_valid = 1'b0;
  int m_idx = 0;

  always #10 clk = ~clk;

  arb2_channel_arbiter #(.NUM_CH(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_pending(req_pending), .chan_prio(chan_prio),
    .bus_idle(bus_idle), .access_done(access_done),
    .grant(grant), .grant_idx(grant_idx), .grant_valid(grant_valid)
  );

  function automatic int winner(logic [N-1:0] p, logic [2*N-1:0] pr);
    int best = -1;
    int best_lvl = -1;
    for (int i = 0; i < N; i++) begin
      if (p[i] && int'(pr[2*i +: 2]) > best_lvl) begin
        best_lvl = int'(pr[2*i +: 2]);
        best = i;
      end
    end
    return best;
  endfunction

  task automatic compare(string tag);
    logic [N-1:0] eg;
    eg = m_valid ? (N'(1) << m_idx) : '0;
    n_cmp++;
    if (grant !== eg || grant_valid !== m_valid ||
        grant_idx !== (m_valid ? IW'(m_idx) : IW'(0))) begin
      n_bad++;
      $display("FAIL %s: grant=%b idx=%0d valid=%b expected grant=%b idx=%0d valid=%b",
               tag, grant, grant_idx, grant_valid, eg, m_valid ? m_idx : 0, m_valid);
    end
  endtask

  // Called at a falling edge: drive, model the next edge, check after it
  task automatic step(logic [N-1:0] p, logic [2*N-1:0] pr, bit idle, bit done);
    string tag;
    int w;
    req_pending = p; chan_prio = pr; bus_idle = idle; access_done = done;
    w = winner(p, pr);
    if (m_valid) begin
      if (done) begin m_valid = 0; m_idx = 0; tag = "R7 release"; end
      else tag = "R6 hold";
    end else if (!idle) tag = "R5 bus busy";
    else if (w < 0) tag = "R2 nothing pending";
    else begin m_valid = 1; m_idx = w; tag = "R3/R4 new grant"; end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset release");

    step('0, '0, 1, 0);                               // R2
    step('0, '0, 1, 1);                               // R7 done ignored without grant
    // R3: ch5 ultra, ch0 low
    step(8'b0010_0001, 16'h0C00, 1, 0);
    step(8'b1111_1111, 16'hFFFF, 1, 0);               // R6 ultra everywhere, hold
    step(8'b1000_0000, 16'hC000, 0, 0);               // R6 hold with ch7 ultra
    step('0, '0, 1, 1);                               // R7
    // R4: ch2 and ch6 high, ch1 medium
    step(8'b0100_0110, 16'h2024, 1, 0);
    step('0, '0, 1, 1);
    // R5: bus busy blocks grant
    step(8'b0000_1000, 16'h0000, 0, 0);
    step(8'b0000_1000, 16'h0000, 0, 1);
    step(8'b0000_1000, 16'h0000, 1, 0);               // now granted ch3
    step(8'b0000_1000, 16'h0000, 1, 1);
    // R4 ties at each level: all pending, same level -> ch0
    for (int l = 0; l < 4; l++) begin
      logic [2*N-1:0] pr;
      for (int c = 0; c < N; c++) pr[2*c +: 2] = 2'(l);
      step('1, pr, 1, 0);
      step('1, pr, 1, 1);
    end
    // R3: only top channel ultra
    step(8'b1000_0001, 16'hC000, 1, 0);
    step('0, '0, 1, 1);

    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] p;
      logic [2*N-1:0] pr;
      p  = N'($urandom);
      if ($urandom_range(0, 7) == 0) p = '0;
      pr = 16'($urandom);
      step(p, pr, $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule